// File: doc/BRIEF.md
# JTAG Configuration Status Pin Controller

This block sits beside the in-system configuration port of a flash-based device and owns the output enables of that port. After power-up every pin of the test port is an input, and the serial data output stays released. A port-enable command turns on the serial output. A second form of that command also brings up two status pins. The ready pin reports whether the flash engine is idle in read-array mode. The error pin, active low, reports a failed sector erase or byte program.

The error indication is sticky. It survives an ordinary chip reset. It is released only by a dedicated clear command, or by a chip reset that follows a configuration-disable command. A mode command switches both status pins to open-drain signalling, in which a high level is made by releasing the output enable instead of driving the pin. All command strobes are single-cycle pulses on the test clock. The engine status inputs are already synchronous to that clock.

The port is governed by a three-state machine. PORT_OFF has every output released. PORT_SERIAL drives only the serial output. PORT_FULL drives the serial output and both status pins. The transitions are:
- PORT_OFF to PORT_SERIAL on the plain enable command.
- PORT_OFF or PORT_SERIAL to PORT_FULL on the enable-with-status command.
- PORT_FULL to PORT_SERIAL on the plain enable command.
- Any state to PORT_OFF on power-on reset or chip reset.

Top module: `cfg_stat_pins`

## Requirements
- R1: On power-on reset (por_n low), and one cycle after a chip reset pulse (chip_rst high), tdo_oe, rdy_oe and err_oe are all 0. The chip reset also returns the status pins to push-pull mode.
- R2: One cycle after cmd_port_on, tdo_oe is 1 and both status output enables stay 0. tdo_o always equals tap_sdo.
- R3: One cycle after cmd_port_on_stat, tdo_oe, rdy_oe and err_oe are all 1. A later cmd_port_on, sent without cmd_port_on_stat in the same cycle, turns rdy_oe and err_oe off again while tdo_oe stays 1.
- R4: In push-pull mode with the status pins enabled, rdy_o is 1 one cycle after eng_busy and sec_wr_busy are both 0. It is 0 one cycle after either of them is 1.
- R5: One cycle after an eng_fail pulse, the error pin shows an active error (err_o = 0 in push-pull mode). The error then stays active for any number of cycles.
- R6: One cycle after cmd_err_clr, the error is released (err_o = 1 in push-pull mode). An eng_fail in the same cycle as cmd_err_clr wins, and the error stays active.
- R7: A chip reset with no cmd_cfg_off issued since the last chip reset or port-enable command leaves the stored error unchanged. It shows again once the status pins are re-enabled.
- R8: A chip reset that follows cmd_cfg_off clears the stored error. A port-enable command issued between the cmd_cfg_off and the chip reset cancels that clear.
- R9: After cmd_set_od, rdy_o and err_o are 0, and each output enable is 1 exactly when its pin level is low (busy, or error active). After cmd_set_pp, both pins are driven again. If both commands arrive in the same cycle, cmd_set_pp wins.
- R10: While the status pins are not enabled, rdy_oe and err_oe stay 0 whatever the busy and error state is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| chip_rst | input | 1 | Synchronous chip reset pulse |
| cmd_port_on | input | 1 | Enable the serial output only |
| cmd_port_on_stat | input | 1 | Enable the serial output and both status pins |
| cmd_set_od | input | 1 | Switch the status pins to open-drain |
| cmd_set_pp | input | 1 | Switch the status pins to push-pull |
| cmd_err_clr | input | 1 | Release the sticky error |
| cmd_cfg_off | input | 1 | Configuration-disable; arms the error clear on the next chip reset |
| eng_busy | input | 1 | Flash program or erase in progress |
| sec_wr_busy | input | 1 | Secondary block write in progress |
| eng_fail | input | 1 | Single-cycle erase or program failure report |
| tap_sdo | input | 1 | Serial data from the test access port |
| tdo_o | output | 1 | Serial data output value |
| tdo_oe | output | 1 | Serial data output enable |
| rdy_o | output | 1 | Ready pin value |
| rdy_oe | output | 1 | Ready pin output enable |
| err_o | output | 1 | Error pin value (low means error) |
| err_oe | output | 1 | Error pin output enable |

## Verification
A lost or spurious error bit stays hidden while the status pins are disabled. It surfaces on err_o in the first cycle after the enable-with-status command, so the bench re-enables the port after every reset and hidden-error case and samples then. A wrong port state shows on the output enables one cycle after the command that should have moved it. A stale open-drain flag shows as a driven-high level where only a released pin is allowed. A disable-arming flag that fails to clear or fails to set shows only after a later chip reset followed by a re-enable, so those sequences are run in both orders.

// File: rtl/cfg_stat_pkg.sv
package cfg_stat_pkg;

    typedef enum logic [1:0] {
        PORT_OFF    = 2'd0,
        PORT_SERIAL = 2'd1,
        PORT_FULL   = 2'd2
    } port_state_e;

    typedef struct packed {
        logic val;
        logic oe;
    } pin_drv_t;

    localparam int unsigned STAT_PINS = 2;
    localparam int unsigned PIN_RDY   = 0;
    localparam int unsigned PIN_ERR   = 1;

endpackage

// File: rtl/cfg_port_fsm.sv
module cfg_port_fsm
    import cfg_stat_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic chip_rst,
    input  logic cmd_port_on,
    input  logic cmd_port_on_stat,
    input  logic cmd_set_od,
    input  logic cmd_set_pp,
    output logic ser_en,
    output logic stat_en,
    output logic od_mode
);

    port_state_e state_q, state_d;
    logic        od_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PORT_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (chip_rst) begin
            state_d = PORT_OFF;
        end else begin
            unique case (state_q)
                PORT_OFF: begin
                    if (cmd_port_on_stat)  state_d = PORT_FULL;
                    else if (cmd_port_on)  state_d = PORT_SERIAL;
                end
                PORT_SERIAL: begin
                    if (cmd_port_on_stat)  state_d = PORT_FULL;
                end
                PORT_FULL: begin
                    if (cmd_port_on && !cmd_port_on_stat) state_d = PORT_SERIAL;
                end
                default: state_d = PORT_OFF;
            endcase
        end
    end

    always_comb begin
        ser_en  = 1'b0;
        stat_en = 1'b0;
        unique case (state_q)
            PORT_OFF:    begin ser_en = 1'b0; stat_en = 1'b0; end
            PORT_SERIAL: begin ser_en = 1'b1; stat_en = 1'b0; end
            PORT_FULL:   begin ser_en = 1'b1; stat_en = 1'b1; end
            default:     begin ser_en = 1'b0; stat_en = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          od_q <= 1'b0;
        else if (chip_rst)   od_q <= 1'b0;
        else if (cmd_set_pp) od_q <= 1'b0;
        else if (cmd_set_od) od_q <= 1'b1;
    end

    assign od_mode = od_q;

    assert_rst_port_off_R1: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst |=> (state_q == PORT_OFF) && !od_q);

    assert_stat_cmd_full_R3: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_port_on_stat && !chip_rst) |=> stat_en && ser_en);

    assert_plain_on_serial_R2: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_port_on && !cmd_port_on_stat && !chip_rst) |=> ser_en && !stat_en);

endmodule

// File: rtl/cfg_err_latch.sv
module cfg_err_latch (
    input  logic clk,
    input  logic por_n,
    input  logic chip_rst,
    input  logic fail_i,
    input  logic cmd_clr,
    input  logic cmd_disable,
    input  logic cmd_rearm,
    output logic err_flag
);

    logic err_q;
    logic armed_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            err_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (chip_rst) begin
            err_q   <= fail_i | (err_q & ~armed_q);
            armed_q <= 1'b0;
        end else begin
            err_q   <= fail_i | (err_q & ~cmd_clr);
            armed_q <= cmd_disable | (armed_q & ~cmd_rearm);
        end
    end

    assign err_flag = err_q;

    assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!por_n)
        fail_i |=> err_q);

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (err_q && !cmd_clr && !chip_rst) |=> err_q);

    assert_clear_cmd_R6: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_clr && !fail_i && !chip_rst) |=> !err_q);

    assert_rst_keeps_R7: assert property (@(posedge clk) disable iff (!por_n)
        (chip_rst && !armed_q && err_q) |=> err_q);

    assert_rst_clears_R8: assert property (@(posedge clk) disable iff (!por_n)
        (chip_rst && armed_q && !fail_i) |=> !err_q);

endmodule

// File: rtl/cfg_pin_drv.sv
module cfg_pin_drv
    import cfg_stat_pkg::*;
(
    input  logic     en,
    input  logic     od,
    input  logic     level,
    output pin_drv_t pin
);

    always_comb begin
        if (!en) begin
            pin.val = 1'b0;
            pin.oe  = 1'b0;
        end else if (od) begin
            pin.val = 1'b0;
            pin.oe  = ~level;
        end else begin
            pin.val = level;
            pin.oe  = 1'b1;
        end
    end

endmodule

// File: rtl/cfg_stat_pins.sv
module cfg_stat_pins
    import cfg_stat_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic chip_rst,
    input  logic cmd_port_on,
    input  logic cmd_port_on_stat,
    input  logic cmd_set_od,
    input  logic cmd_set_pp,
    input  logic cmd_err_clr,
    input  logic cmd_cfg_off,
    input  logic eng_busy,
    input  logic sec_wr_busy,
    input  logic eng_fail,
    input  logic tap_sdo,
    output logic tdo_o,
    output logic tdo_oe,
    output logic rdy_o,
    output logic rdy_oe,
    output logic err_o,
    output logic err_oe
);

    logic ser_en, stat_en, od_mode;
    logic err_flag;
    logic ready_q;
    logic [STAT_PINS-1:0] level;
    pin_drv_t             pins [STAT_PINS];

    cfg_port_fsm u_fsm (
        .clk              (clk),
        .por_n            (por_n),
        .chip_rst         (chip_rst),
        .cmd_port_on      (cmd_port_on),
        .cmd_port_on_stat (cmd_port_on_stat),
        .cmd_set_od       (cmd_set_od),
        .cmd_set_pp       (cmd_set_pp),
        .ser_en           (ser_en),
        .stat_en          (stat_en),
        .od_mode          (od_mode)
    );

    cfg_err_latch u_err (
        .clk         (clk),
        .por_n       (por_n),
        .chip_rst    (chip_rst),
        .fail_i      (eng_fail),
        .cmd_clr     (cmd_err_clr),
        .cmd_disable (cmd_cfg_off),
        .cmd_rearm   (cmd_port_on | cmd_port_on_stat),
        .err_flag    (err_flag)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ready_q <= 1'b1;
        else        ready_q <= ~(eng_busy | sec_wr_busy);
    end

    assign level[PIN_RDY] = ready_q;
    assign level[PIN_ERR] = ~err_flag;

    for (genvar g = 0; g < STAT_PINS; g++) begin : g_pin
        cfg_pin_drv u_drv (
            .en    (stat_en),
            .od    (od_mode),
            .level (level[g]),
            .pin   (pins[g])
        );
    end

    assign tdo_o  = tap_sdo;
    assign tdo_oe = ser_en;
    assign rdy_o  = pins[PIN_RDY].val;
    assign rdy_oe = pins[PIN_RDY].oe;
    assign err_o  = pins[PIN_ERR].val;
    assign err_oe = pins[PIN_ERR].oe;

    assert_rst_outputs_off_R1: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst |=> !tdo_oe && !rdy_oe && !err_oe);

    assert_busy_low_R4: assert property (@(posedge clk) disable iff (!por_n)
        (stat_en && !od_mode && $past(eng_busy | sec_wr_busy)) |-> !rdy_o);

    assert_od_no_drive_high_R9: assert property (@(posedge clk) disable iff (!por_n)
        od_mode |-> !rdy_o && !err_o);

    assert_hidden_status_R10: assert property (@(posedge clk) disable iff (!por_n)
        !stat_en |-> !rdy_oe && !err_oe);

endmodule

// File: tb/tb_cfg_stat_pins.sv
module tb_cfg_stat_pins;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic chip_rst = 1'b0;
    logic cmd_port_on = 1'b0, cmd_port_on_stat = 1'b0;
    logic cmd_set_od = 1'b0, cmd_set_pp = 1'b0;
    logic cmd_err_clr = 1'b0, cmd_cfg_off = 1'b0;
    logic eng_busy = 1'b0, sec_wr_busy = 1'b0, eng_fail = 1'b0;
    logic tap_sdo = 1'b0;
    logic tdo_o, tdo_oe, rdy_o, rdy_oe, err_o, err_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cfg_stat_pins dut (
        .clk(clk), .por_n(por_n), .chip_rst(chip_rst),
        .cmd_port_on(cmd_port_on), .cmd_port_on_stat(cmd_port_on_stat),
        .cmd_set_od(cmd_set_od), .cmd_set_pp(cmd_set_pp),
        .cmd_err_clr(cmd_err_clr), .cmd_cfg_off(cmd_cfg_off),
        .eng_busy(eng_busy), .sec_wr_busy(sec_wr_busy), .eng_fail(eng_fail),
        .tap_sdo(tap_sdo), .tdo_o(tdo_o), .tdo_oe(tdo_oe),
        .rdy_o(rdy_o), .rdy_oe(rdy_oe), .err_o(err_o), .err_oe(err_oe)
    );

    // packed view: {tdo_oe, rdy_o, rdy_oe, err_o, err_oe}
    function automatic logic [4:0] pins();
        return {tdo_oe, rdy_o, rdy_oe, err_o, err_oe};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one-cycle pulse on a strobe: driven at a falling edge, sampled one edge later
    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 power-on", pins(), 5'b00000);
    endtask

    task automatic t_serial();
        pulse(cmd_port_on);
        check("R2 serial only", pins(), 5'b10000);
        tap_sdo = 1'b1; #1;
        check("R2 tdo follows", {4'b0, tdo_o}, 5'b00001);
        tap_sdo = 1'b0; #1;
        check("R2 tdo follows low", {4'b0, tdo_o}, 5'b00000);
    endtask

    task automatic t_full();
        pulse(cmd_port_on_stat);
        check("R3 full enable", pins(), 5'b11111);
        pulse(cmd_port_on);
        check("R3 back to serial", pins(), 5'b10000);
        pulse(cmd_port_on_stat);
        check("R3 full again", pins(), 5'b11111);
    endtask

    task automatic t_busy();
        @(negedge clk) eng_busy = 1'b1;
        step();
        check("R4 eng busy", pins(), 5'b10111);
        @(negedge clk) begin eng_busy = 1'b0; sec_wr_busy = 1'b1; end
        step();
        check("R4 sec write busy", pins(), 5'b10111);
        @(negedge clk) sec_wr_busy = 1'b0;
        step();
        check("R4 ready again", pins(), 5'b11111);
    endtask

    task automatic t_error();
        pulse(eng_fail);
        check("R5 error shown", pins(), 5'b11101);
        repeat (6) step();
        check("R5 error sticky", pins(), 5'b11101);
        pulse(cmd_err_clr);
        check("R6 clear", pins(), 5'b11111);
        @(negedge clk) begin eng_fail = 1'b1; cmd_err_clr = 1'b1; end
        @(negedge clk) begin eng_fail = 1'b0; cmd_err_clr = 1'b0; end
        check("R6 fail wins over clear", pins(), 5'b11101);
        pulse(cmd_err_clr);
        check("R6 clear again", pins(), 5'b11111);
    endtask

    task automatic t_hidden();
        pulse(cmd_port_on);
        @(negedge clk) begin eng_fail = 1'b1; eng_busy = 1'b1; end
        @(negedge clk) eng_fail = 1'b0;
        check("R10 status hidden", pins(), 5'b10000);
        @(negedge clk) eng_busy = 1'b0;
        pulse(cmd_port_on_stat);
        check("R10 error revealed", pins(), 5'b11101);
        pulse(cmd_err_clr);
    endtask

    task automatic t_reset_keep();
        pulse(eng_fail);
        pulse(chip_rst);
        check("R1 chip reset releases", pins(), 5'b00000);
        pulse(cmd_port_on_stat);
        check("R7 error kept over reset", pins(), 5'b11101);
    endtask

    task automatic t_disable();
        pulse(cmd_cfg_off);
        pulse(chip_rst);
        pulse(cmd_port_on_stat);
        check("R8 reset after disable clears", pins(), 5'b11111);
        pulse(eng_fail);
        pulse(cmd_cfg_off);
        pulse(cmd_port_on);
        pulse(chip_rst);
        pulse(cmd_port_on_stat);
        check("R8 enable cancels arm", pins(), 5'b11101);
        pulse(cmd_err_clr);
        check("R6 cleanup", pins(), 5'b11111);
    endtask

    task automatic t_open_drain();
        pulse(cmd_set_od);
        check("R9 od idle released", pins(), 5'b10000);
        @(negedge clk) eng_busy = 1'b1;
        step();
        check("R9 od busy pulls low", pins(), 5'b10100);
        @(negedge clk) eng_busy = 1'b0;
        pulse(eng_fail);
        check("R9 od error pulls low", pins(), 5'b10001);
        @(negedge clk) begin cmd_set_od = 1'b1; cmd_set_pp = 1'b1; end
        @(negedge clk) begin cmd_set_od = 1'b0; cmd_set_pp = 1'b0; end
        check("R9 pp wins", pins(), 5'b11101);
        pulse(cmd_err_clr);
        pulse(cmd_set_od);
        pulse(chip_rst);
        pulse(cmd_port_on_stat);
        check("R1 reset restores push-pull", pins(), 5'b11111);
    endtask

    initial begin
        #3;
        check("R1 power-on async", pins(), 5'b00000);
        repeat (3) step();
        por_n = 1'b1;
        step();
        t_reset();
        t_serial();
        t_full();
        t_busy();
        t_error();
        t_hidden();
        t_reset_keep();
        t_disable();
        t_open_drain();
        step();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule